// File: doc/BRIEF.md
# Chip-select-gated command register

This block sits on the command/address path of a memory module. On every rising clock edge it captures 28 command and address inputs and drives each captured value out on two identical output copies, so that one register stage feeds two loads.

To save power, a static gating-enable input can restrict updates to the 22 command/address signals: 16 address bits, 3 bank bits and the row strobe, column strobe and write strobe. With gating enabled, these signals are only recaptured on cycles where at least one of the four active-low chip selects is low; otherwise they keep their previous value. The chip selects, the clock enable and the termination control are recaptured on every edge. With gating disabled, every bit is recaptured on every edge. An active-low asynchronous reset clears the register, and all outputs go low.

Top module: `csg_cmd_reg`

## Requirements
- R1: While `rst_n` is low, every output is 0. This takes effect asynchronously, without waiting for a clock edge.
- R2: With `gate_en` = 1 and at least one bit of `cs_n_in` equal to 0 at a rising edge, the address, bank, ras, cas and we outputs take the input values sampled at that edge.
- R3: With `gate_en` = 1 and `cs_n_in` = 4'b1111 at a rising edge, the address, bank, ras, cas and we outputs keep their previous values.
- R4: The chip-select, clock-enable and termination outputs take the input values sampled at every rising edge, whatever the values of `gate_en` and `cs_n_in`.
- R5: With `gate_en` = 0, all 28 outputs take the input values sampled at every rising edge.
- R6: The `_a` and `_b` copies of each output are equal at all times.
- R7: After `rst_n` rises, the first rising edge captures the inputs under the normal rules.
- R8: Each of the four chip-select bits, when it is the only bit held low, is enough on its own to enable the gated capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | 1 = gated command/address capture |
| cs_n_in | input | 4 | Chip selects, active low |
| cke_in | input | 1 | Clock enable |
| odt_in | input | 1 | Termination control |
| addr_in | input | 16 | Address |
| bank_in | input | 3 | Bank address |
| ras_n_in | input | 1 | Row strobe |
| cas_n_in | input | 1 | Column strobe |
| we_n_in | input | 1 | Write strobe |
| cs_n_a | output | 4 | Chip selects, copy A |
| cke_a | output | 1 | Clock enable, copy A |
| odt_a | output | 1 | Termination, copy A |
| addr_a | output | 16 | Address, copy A |
| bank_a | output | 3 | Bank, copy A |
| ras_n_a | output | 1 | Row strobe, copy A |
| cas_n_a | output | 1 | Column strobe, copy A |
| we_n_a | output | 1 | Write strobe, copy A |
| cs_n_b | output | 4 | Chip selects, copy B |
| cke_b | output | 1 | Clock enable, copy B |
| odt_b | output | 1 | Termination, copy B |
| addr_b | output | 16 | Address, copy B |
| bank_b | output | 3 | Bank, copy B |
| ras_n_b | output | 1 | Row strobe, copy B |
| cas_n_b | output | 1 | Column strobe, copy B |
| we_n_b | output | 1 | Write strobe, copy B |

## Verification
The hold case is the one that uniform random stimulus hardly ever reaches: all four chip selects must be high while the gated inputs change, and then an enabling cycle must follow. The random generator therefore draws the chip-select field with a bias toward 4'b1111 and toward a single low bit. Directed runs then hold the address stream steady while every chip select is high, toggle gating off in the middle of an idle stretch, and assert reset between clock edges.

// File: rtl/csg_cmd_reg.sv
module csg_cmd_reg #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter int CS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [CS_W-1:0]   cs_n_in,
  input  logic              cke_in,
  input  logic              odt_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              ras_n_in,
  input  logic              cas_n_in,
  input  logic              we_n_in,
  output logic [CS_W-1:0]   cs_n_a,
  output logic              cke_a,
  output logic              odt_a,
  output logic [ADDR_W-1:0] addr_a,
  output logic [BANK_W-1:0] bank_a,
  output logic              ras_n_a,
  output logic              cas_n_a,
  output logic              we_n_a,
  output logic [CS_W-1:0]   cs_n_b,
  output logic              cke_b,
  output logic              odt_b,
  output logic [ADDR_W-1:0] addr_b,
  output logic [BANK_W-1:0] bank_b,
  output logic              ras_n_b,
  output logic              cas_n_b,
  output logic              we_n_b
);
  localparam int GW = ADDR_W + BANK_W + 3;
  localparam int FW = CS_W + 2;

  logic [GW-1:0] gated_q;
  logic [FW-1:0] free_q;
  logic          cmd_hit, upd;

  assign cmd_hit = ~&cs_n_in;
  assign upd     = ~gate_en | cmd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated_q <= '0;
      free_q  <= '0;
    end else begin
      free_q <= {cs_n_in, cke_in, odt_in};
      if (upd) gated_q <= {addr_in, bank_in, ras_n_in, cas_n_in, we_n_in};
    end
  end

  assign {cs_n_a, cke_a, odt_a} = free_q;
  assign {cs_n_b, cke_b, odt_b} = free_q;
  assign {addr_a, bank_a, ras_n_a, cas_n_a, we_n_a} = gated_q;
  assign {addr_b, bank_b, ras_n_b, cas_n_b, we_n_b} = gated_q;

  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |-> (addr_a == '0 && cs_n_a == '0 && cke_b == 1'b0 && we_n_b == 1'b0));

  p_gated_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !(&cs_n_in)) |=> (addr_a == $past(addr_in) && bank_a == $past(bank_in)
      && ras_n_a == $past(ras_n_in) && we_n_a == $past(we_n_in)));

  p_gated_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (&cs_n_in)) |=> ($stable(addr_a) && $stable(bank_a) && $stable(cas_n_a)));

  p_free_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_n_a == $past(cs_n_in) && cke_a == $past(cke_in) && odt_a == $past(odt_in)));

  p_ungated_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (addr_b == $past(addr_in) && bank_b == $past(bank_in) && cas_n_b == $past(cas_n_in)));

  p_copies_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_a == addr_b && cs_n_a == cs_n_b && bank_a == bank_b && odt_a == odt_b));
endmodule

// File: tb/tb_csg_cmd_reg.sv
module tb_csg_cmd_reg;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b1;
  logic [3:0] cs_n_in = 4'hF;
  logic cke_in = 0, odt_in = 0, ras_n_in = 0, cas_n_in = 0, we_n_in = 0;
  logic [15:0] addr_in = '0;
  logic [2:0] bank_in = '0;
  logic [3:0] cs_n_a, cs_n_b;
  logic cke_a, odt_a, ras_n_a, cas_n_a, we_n_a;
  logic cke_b, odt_b, ras_n_b, cas_n_b, we_n_b;
  logic [15:0] addr_a, addr_b;
  logic [2:0] bank_a, bank_b;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [27:0] model = '0;

  always #(PERIOD/2) clk = ~clk;

  csg_cmd_reg dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n_in(cs_n_in),
    .cke_in(cke_in), .odt_in(odt_in), .addr_in(addr_in), .bank_in(bank_in),
    .ras_n_in(ras_n_in), .cas_n_in(cas_n_in), .we_n_in(we_n_in),
    .cs_n_a(cs_n_a), .cke_a(cke_a), .odt_a(odt_a), .addr_a(addr_a), .bank_a(bank_a),
    .ras_n_a(ras_n_a), .cas_n_a(cas_n_a), .we_n_a(we_n_a),
    .cs_n_b(cs_n_b), .cke_b(cke_b), .odt_b(odt_b), .addr_b(addr_b), .bank_b(bank_b),
    .ras_n_b(ras_n_b), .cas_n_b(cas_n_b), .we_n_b(we_n_b));

  // layout: [27:24] cs, [23] cke, [22] odt, [21:6] addr, [5:3] bank, [2] ras, [1] cas, [0] we
  function automatic logic [27:0] in_vec();
    return {cs_n_in, cke_in, odt_in, addr_in, bank_in, ras_n_in, cas_n_in, we_n_in};
  endfunction

  function automatic logic [27:0] next_model(logic [27:0] cur, logic [27:0] inp, logic gen);
    logic [27:0] r;
    r = cur;
    r[27:22] = inp[27:22];
    if (!gen || (inp[27:24] != 4'hF)) r[21:0] = inp[21:0];
    return r;
  endfunction

  function automatic logic [27:0] out_a();
    return {cs_n_a, cke_a, odt_a, addr_a, bank_a, ras_n_a, cas_n_a, we_n_a};
  endfunction
  function automatic logic [27:0] out_b();
    return {cs_n_b, cke_b, odt_b, addr_b, bank_b, ras_n_b, cas_n_b, we_n_b};
  endfunction

  task automatic chk(string req, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic ge, logic [3:0] cs, logic [21:0] g, logic [1:0] co);
    gate_en = ge;
    cs_n_in = cs;
    {cke_in, odt_in} = co;
    {addr_in, bank_in, ras_n_in, cas_n_in, we_n_in} = g;
  endtask

  task automatic step(string req);
    @(posedge clk);
    model = next_model(model, in_vec(), gate_en);
    @(negedge clk);
    chk(req, out_a(), model);
    chk("R6", out_b(), out_a());
  endtask

  function automatic logic [3:0] pick_cs();
    int k;
    k = $urandom_range(0, 3);
    if (k == 0) return 4'hF;
    if (k == 1) return ~(4'b1 << $urandom_range(0, 3));
    return 4'($urandom);
  endfunction

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    drive(1'b0, 4'h0, 22'h3FFFFF, 2'b11);
    @(negedge clk);
    chk("R1 reset", out_a(), '0);
    chk("R1 reset copy b", out_b(), '0);
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    // R7: first edge after release captures
    step("R7 first edge after release");

    // R5 gating off, all high cs still captures
    drive(1'b0, 4'hF, 22'h12345, 2'b01);
    step("R5 ungated capture");

    // R3 hold: gated, all cs high, changing gated inputs
    drive(1'b1, 4'hF, 22'h2AAAAA, 2'b10);
    step("R3 hold");
    drive(1'b1, 4'hF, 22'h155555, 2'b00);
    step("R3 hold again, R4 free bits follow");

    // R8 each chip select alone
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, ~(4'b1 << i), 22'(32'h1000 * (i + 3) + i), 2'(i));
      step("R8 single cs enables capture");
      drive(1'b1, 4'hF, 22'(32'hABC * (i + 1)), 2'(i + 1));
      step("R3 hold after single cs");
    end

    // R2 gated capture with all cs low
    drive(1'b1, 4'h0, 22'h3C3C3C, 2'b11);
    step("R2 gated capture");

    // toggle gating off during idle
    drive(1'b1, 4'hF, 22'h0F0F0, 2'b00);
    step("R3 idle hold");
    drive(1'b0, 4'hF, 22'h0F0F0, 2'b00);
    step("R5 gating switched off in idle");

    // random mix
    for (int n = 0; n < 400; n++) begin
      drive(($urandom_range(0, 3) != 0), pick_cs(), 22'($urandom), 2'($urandom));
      step("R2/R3/R4/R5 random");
    end

    // R1 async reset between edges
    drive(1'b0, 4'h5, 22'h3FFFFF, 2'b11);
    step("R5 before reset");
    #(PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", out_a(), '0);
    chk("R1 async clear copy b", out_b(), '0);
    @(negedge clk);
    chk("R1 held in reset", out_a(), '0);
    rst_n = 1'b1;
    model = '0;
    drive(1'b1, 4'hF, 22'h2468A, 2'b10);
    step("R7 resume with gating, R3 holds cleared value");
    drive(1'b1, 4'hE, 22'h13579, 2'b01);
    step("R7 resume capture");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule